// File: doc/BRIEF.md
# Dual-bank APB Interrupt Controller

A root interrupt controller for a single CPU, reached over an APB-style slave port. Each controller unit serves 64 interrupt lines split into two 32-bit banks; the top instantiates a parameterised number of units, each at its own 256-byte window, so the default of two units covers 128 lines. Software enables lines bank by bank, reads which enabled lines are pending, and arms the whole unit with one control bit. The block drives one level-sensitive request to the CPU.

A build-time parameter picks how lines are observed. In level mode a pending bit is just the live line ANDed with its enable. In pulse mode every line is caught in a sticky flag register, so a one-cycle pulse is not lost. The pending bit is then the flag ANDed with the enable, and software clears a flag by writing 0 to its bit. Each unit also has a table of 64 byte-wide slots that software fills to assign lines to priority channels. The hardware only stores the table and returns it on reads; it does not use the values.

Top module: `apb_irq_ctrl`

## Requirements
- R1: After reset all control, enable, flag and slot registers read 0 and `irq_o` is low.
- R2: The enable registers sit at unit offsets 0x10 (lines 0–31) and 0x28 (lines 32–63). Bit N set to 1 enables line N of that bank. The registers read back as written.
- R3: The pending registers are read-only and sit at 0x14 (lines 0–31) and 0x2C (lines 32–63). In level mode bit N equals line N ANDed with its enable. Writes to a pending register change nothing.
- R4: In pulse mode the flag registers sit 8 bytes below the matching enable register, at 0x08 and 0x20. A line that is high at a clock edge sets its flag bit whether or not the line is enabled, and the bit stays set after the line falls. Pending bit N equals flag N ANDed with enable N.
- R5: A write to a flag register clears exactly the bits written as 0 and leaves the bits written as 1 unchanged. If a line is high at the same edge as a write that clears its bit, the flag stays set.
- R6: The control register sits at offset 0x00, and only bit 31 (unit enable) is stored. `irq_o` is high when some unit has bit 31 set and at least one pending bit. It is low while every unit whose pending bits are non-zero has bit 31 clear.
- R7: The slot table spans 0x40–0x7C as 16 read/write words. Each word holds four byte-wide slots, and every word reads back as written.
- R8: Unit u occupies addresses u×0x100 to u×0x100+0xFF with the same layout and serves lines 64u to 64u+63. A write to one unit leaves every other unit unchanged.
- R9: `pready_o` is always high and every access takes one access cycle. Reads of unmapped offsets, or of windows above the last unit, return 0. Writes to them change no register.
- R10: In level mode the flag registers read 0 and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, always high |
| src_i | input | N_UNITS×64 | Interrupt lines |
| irq_o | output | 1 | Level interrupt request to the CPU |

## Verification
In pulse mode, a software write that clears a flag and a line that sets the same flag can land on the same clock edge. The bench holds a line high across the access cycle of a write that clears that bit, then drops the line and reads the flag register; the flag must still be set. A second write, made while the line is low, must then clear it. A pulse-mode and a level-mode instance share one bus and one set of lines. A behavioural model tracks both, and the bench compares each instance's `irq_o` with the model on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int BANK_W       = 32;
  localparam int BANKS        = 2;
  localparam int SRC_PER_UNIT = BANK_W * BANKS;
  localparam int SLOT_WORDS   = SRC_PER_UNIT / 4;
  localparam int SLOT_IDX_W   = $clog2(SLOT_WORDS);
  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] SLOT_BASE = 8'h40;

  function automatic logic [7:0] en_off(input int b);
    return (b == 0) ? 8'h10 : 8'h28;
  endfunction

  // flag register lives 8 bytes below its enable register
  function automatic logic [7:0] flag_off(input int b);
    return en_off(b) - 8'h08;
  endfunction

  function automatic logic [7:0] pend_off(input int b);
    return en_off(b) + 8'h04;
  endfunction
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int W     = 32,
  parameter bit PULSE = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         en_we_i,
  input  logic         flag_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= wdata_i;
  end

  assign en_o = en_q;

  a_r2_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> $stable(en_q));

  if (PULSE) begin : g_pulse
    logic [W-1:0] flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q <= '0;
      else if (flag_we_i) flag_q <= (flag_q & wdata_i) | src_i;  // capture beats clear
      else                flag_q <= flag_q | src_i;
    end
    assign flag_o = flag_q;
    assign pend_o = flag_q & en_q;

    a_r4_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !flag_we_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
    a_r5_capture_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((flag_q & $past(src_i)) == $past(src_i)));
  end else begin : g_level
    assign flag_o = '0;
    assign pend_o = src_i & en_q;
  end
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import irq_pkg::*;
#(
  parameter bit PULSE = 1'b0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [SRC_PER_UNIT-1:0] src_i,
  input  logic                    we_i,
  input  logic [7:0]              addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  output logic                    irq_o
);
  localparam logic [7:0] SLOT_END = SLOT_BASE + 8'(4 * SLOT_WORDS);

  logic                          ctrl_q;
  logic [BANKS-1:0][BANK_W-1:0]  en_w, flag_w, pend_w;
  logic [BANKS-1:0]              pend_any;
  logic [31:0]                   slot_q [SLOT_WORDS];
  logic                          in_slots;
  logic [SLOT_IDX_W-1:0]         slot_idx;
  logic [7:0]                    slot_rel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ctrl_q <= 1'b0;
    else if (we_i && addr_i == OFF_CTRL)  ctrl_q <= wdata_i[31];
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    irq_bank #(.W(BANK_W), .PULSE(PULSE)) i_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (src_i[b*BANK_W +: BANK_W]),
      .en_we_i   (we_i && addr_i == en_off(b)),
      .flag_we_i (we_i && addr_i == flag_off(b)),
      .wdata_i   (wdata_i),
      .en_o      (en_w[b]),
      .flag_o    (flag_w[b]),
      .pend_o    (pend_w[b])
    );
    assign pend_any[b] = |pend_w[b];
  end

  assign in_slots = (addr_i >= SLOT_BASE) && (addr_i < SLOT_END) && (addr_i[1:0] == 2'b00);
  assign slot_rel = addr_i - SLOT_BASE;
  assign slot_idx = slot_rel[2 +: SLOT_IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SLOT_WORDS; i++) slot_q[i] <= '0;
    end else if (we_i && in_slots) begin
      slot_q[slot_idx] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFF_CTRL) rdata_o = {ctrl_q, 31'b0};
    for (int b = 0; b < BANKS; b++) begin
      if (addr_i == en_off(b))   rdata_o = en_w[b];
      if (addr_i == flag_off(b)) rdata_o = flag_w[b];
      if (addr_i == pend_off(b)) rdata_o = pend_w[b];
    end
    if (in_slots) rdata_o = slot_q[slot_idx];
  end

  assign irq_o = ctrl_q && (|pend_any);

  a_r6_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q |-> !irq_o);
endmodule

// File: rtl/apb_irq_ctrl.sv
module apb_irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_UNITS    = 2,
  parameter bit PULSE_MODE = 1'b1,
  parameter int ADDR_W     = 12
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            psel_i,
  input  logic                            penable_i,
  input  logic                            pwrite_i,
  input  logic [ADDR_W-1:0]               paddr_i,
  input  logic [31:0]                     pwdata_i,
  output logic [31:0]                     prdata_o,
  output logic                            pready_o,
  input  logic [N_UNITS*SRC_PER_UNIT-1:0] src_i,
  output logic                            irq_o
);
  localparam int UIDX_W = ADDR_W - 8;

  logic              wr_acc;
  logic [UIDX_W-1:0] unit_sel;
  logic [31:0]       u_rdata [N_UNITS];
  logic [N_UNITS-1:0] u_irq;

  assign wr_acc   = psel_i && penable_i && pwrite_i;
  assign unit_sel = paddr_i[ADDR_W-1:8];
  assign pready_o = 1'b1;

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    irq_unit #(.PULSE(PULSE_MODE)) i_unit (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (src_i[u*SRC_PER_UNIT +: SRC_PER_UNIT]),
      .we_i    (wr_acc && unit_sel == UIDX_W'(u)),
      .addr_i  (paddr_i[7:0]),
      .wdata_i (pwdata_i),
      .rdata_o (u_rdata[u]),
      .irq_o   (u_irq[u])
    );
  end

  always_comb begin
    prdata_o = '0;
    for (int u = 0; u < N_UNITS; u++)
      if (unit_sel == UIDX_W'(u)) prdata_o = u_rdata[u];
  end

  assign irq_o = |u_irq;

  a_r6_req_from_unit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (u_irq != '0));
endmodule

// File: tb/test_apb_irq_ctrl.sv
module test_apb_irq_ctrl;
  localparam int NU = 2;
  localparam int AW = 12;
  localparam int NS = NU * 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [NS-1:0] src = '0;
  logic [31:0] rd_p, rd_l;
  logic rdy_p, rdy_l, irq_p, irq_l;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  apb_irq_ctrl #(.N_UNITS(NU), .PULSE_MODE(1'b1), .ADDR_W(AW)) i_apb_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(rd_p), .pready_o(rdy_p),
    .src_i(src), .irq_o(irq_p));

  apb_irq_ctrl #(.N_UNITS(NU), .PULSE_MODE(1'b0), .ADDR_W(AW)) i_lvl (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(rd_l), .pready_o(rdy_l),
    .src_i(src), .irq_o(irq_l));

  // behavioural reference
  bit          m_ctrl [NU];
  logic [31:0] m_en   [NU][2];
  logic [31:0] m_flag [NU][2];
  logic [31:0] m_slot [NU][16];

  function automatic logic [31:0] line_word(int u, int b);
    return src[u*64 + b*32 +: 32];
  endfunction

  function automatic logic [31:0] m_pend(bit pulse, int u, int b);
    return (pulse ? m_flag[u][b] : line_word(u, b)) & m_en[u][b];
  endfunction

  function automatic bit m_irq(bit pulse);
    bit r = 0;
    for (int u = 0; u < NU; u++)
      if (m_ctrl[u] && (m_pend(pulse, u, 0) != 0 || m_pend(pulse, u, 1) != 0)) r = 1;
    return r;
  endfunction

  function automatic logic [31:0] m_read(bit pulse, logic [AW-1:0] a);
    int u = int'(a[AW-1:8]);
    int o = int'(a[7:0]);
    if (u >= NU) return 32'h0;
    case (o)
      'h00: return {m_ctrl[u], 31'b0};
      'h08: return pulse ? m_flag[u][0] : 32'h0;
      'h20: return pulse ? m_flag[u][1] : 32'h0;
      'h10: return m_en[u][0];
      'h28: return m_en[u][1];
      'h14: return m_pend(pulse, u, 0);
      'h2C: return m_pend(pulse, u, 1);
      default: begin
        if (o >= 'h40 && o < 'h80 && o % 4 == 0) return m_slot[u][(o - 'h40) / 4];
        return 32'h0;
      end
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int u = 0; u < NU; u++) begin
        m_ctrl[u] = 0;
        for (int b = 0; b < 2; b++) begin m_en[u][b] = 0; m_flag[u][b] = 0; end
        for (int w = 0; w < 16; w++) m_slot[u][w] = 0;
      end
    end else begin
      bit we;
      int u, o;
      we = psel && penable && pwrite;
      u = int'(paddr[AW-1:8]);
      o = int'(paddr[7:0]);
      for (int uu = 0; uu < NU; uu++)
        for (int b = 0; b < 2; b++) begin
          logic [31:0] nf;
          nf = m_flag[uu][b];
          if (we && u == uu && o == (b == 0 ? 'h08 : 'h20)) nf = nf & pwdata;
          m_flag[uu][b] = nf | line_word(uu, b);
        end
      if (we && u < NU) begin
        if (o == 'h00) m_ctrl[u] = pwdata[31];
        if (o == 'h10) m_en[u][0] = pwdata;
        if (o == 'h28) m_en[u][1] = pwdata;
        if (o >= 'h40 && o < 'h80 && o % 4 == 0) m_slot[u][(o - 'h40) / 4] = pwdata;
      end
    end
  end

  // R6: request line compared with the model on every clock
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      checks += 2;
      if (irq_p !== m_irq(1)) begin
        errors++; $display("FAIL R6 pulse irq_o act=%b exp=%b t=%0t", irq_p, m_irq(1), $time);
      end
      if (irq_l !== m_irq(0)) begin
        errors++; $display("FAIL R6 level irq_o act=%b exp=%b t=%0t", irq_l, m_irq(0), $time);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1;
    checks += 3;
    if (rd_p !== m_read(1, a)) begin
      errors++; $display("FAIL %s pulse addr=%h act=%h exp=%h", tag, a, rd_p, m_read(1, a));
    end
    if (rd_l !== m_read(0, a)) begin
      errors++; $display("FAIL %s level addr=%h act=%h exp=%h", tag, a, rd_l, m_read(0, a));
    end
    if (rdy_p !== 1'b1 || rdy_l !== 1'b1) begin
      errors++; $display("FAIL R9 pready act=%b%b exp=11", rdy_p, rdy_l);
    end
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rd_all(input string tag);
    for (int u = 0; u < NU; u++) begin
      rd(AW'(u*256 + 'h00), tag); rd(AW'(u*256 + 'h08), tag);
      rd(AW'(u*256 + 'h10), tag); rd(AW'(u*256 + 'h14), tag);
      rd(AW'(u*256 + 'h20), tag); rd(AW'(u*256 + 'h28), tag);
      rd(AW'(u*256 + 'h2C), tag);
    end
  endtask

  task automatic pulse(input int i);
    @(negedge clk); src[i] = 1;
    @(negedge clk); src[i] = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    checks++;
    if (irq_p !== 1'b0 || irq_l !== 1'b0) begin
      errors++; $display("FAIL R1 irq after reset act=%b%b exp=00", irq_p, irq_l);
    end
    rd_all("R1");
    rd('h040, "R1"); rd('h17C, "R1");

    // R2 enables, R6 arming
    wr('h000, 32'h8000_0000); wr('h100, 32'hFFFF_FFFF);
    wr('h010, 32'h0000_00F1); wr('h028, 32'h8000_0001);
    rd('h000, "R6"); rd('h100, "R6"); rd('h010, "R2"); rd('h028, "R2");

    // R3 level pending; R4 pulse capture of held lines
    @(negedge clk); src[4] = 1; src[5] = 1; src[40] = 1;
    rd('h014, "R3"); rd('h02C, "R3"); rd('h008, "R4"); rd('h020, "R4");
    @(negedge clk); src[63] = 1;
    rd('h02C, "R3");
    @(negedge clk); src[4] = 0; src[5] = 0; src[40] = 0; src[63] = 0;
    rd('h014, "R4"); rd('h02C, "R4");
    // R3 writes to pending ignored
    wr('h014, 32'hFFFF_FFFF); wr('h02C, 32'h0);
    rd('h010, "R3"); rd('h014, "R3"); rd('h02C, "R3");

    // R5 clear only zeros
    wr('h008, 32'hFFFF_FFEF); rd('h008, "R5");
    wr('h008, 32'h0); wr('h020, 32'h0); rd('h008, "R5"); rd('h020, "R5");
    // R4 single-cycle pulse on a disabled then enabled line
    pulse(1); rd('h008, "R4"); rd('h014, "R4");
    pulse(0); rd('h008, "R4"); rd('h014, "R4");
    // R5 same-edge capture and clear
    @(negedge clk); src[3] = 1;
    wr('h008, 32'h0);
    @(negedge clk); src[3] = 0;
    rd('h008, "R5");
    wr('h008, 32'h0); rd('h008, "R5");

    // R7 slot table, descending byte pattern per word
    for (int u = 0; u < NU; u++)
      for (int w = 0; w < 16; w++) begin
        logic [7:0] k;
        k = 8'(4*w + 64*u);
        wr(AW'(u*256 + 'h40 + 4*w), {k, k + 8'd1, k + 8'd2, k + 8'd3});
      end
    for (int u = 0; u < NU; u++)
      for (int w = 0; w < 16; w++) rd(AW'(u*256 + 'h40 + 4*w), "R7");

    // R8 second unit
    wr('h110, 32'h0000_0004);
    pulse(66); rd('h108, "R8"); rd('h114, "R8"); rd('h008, "R8"); rd('h010, "R8");
    @(negedge clk); src[66] = 1;
    rd('h114, "R8");
    @(negedge clk); src[66] = 0;
    wr('h100, 32'h0); rd('h114, "R6");
    wr('h000, 32'h0); rd('h014, "R6");
    wr('h108, 32'h0); wr('h008, 32'h0); wr('h020, 32'h0);
    wr('h000, 32'h8000_0000);

    // R9 unmapped
    rd('h004, "R9"); rd('h00C, "R9"); rd('h030, "R9"); rd('h080, "R9");
    rd('h0FC, "R9"); rd('h200, "R9"); rd('h310, "R9");
    wr('h004, 32'hFFFF_FFFF); wr('h080, 32'hFFFF_FFFF);
    wr('h210, 32'hFFFF_FFFF); wr('h240, 32'h1234_5678);
    rd_all("R9"); rd('h040, "R9"); rd('h140, "R9");

    // R10 level flag writes ignored (pulse instance sees same write)
    @(negedge clk); src[2] = 1;
    wr('h008, 32'hFFFF_FFFF);
    @(negedge clk); src[2] = 0;
    rd('h008, "R10"); rd('h020, "R10");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule